// File: doc/BRIEF.md
# Branch, Call and Return Sequencer

This block runs the control-transfer instructions of a 12-bit processor: direct and conditional jumps, calls and returns, plus a single-word call that goes indirectly through a pointer table at the bottom of memory. A decoder hands it an instruction word with a `start` strobe, together with the Z, C, N and V flags and the current PC, F, S and SP. The block evaluates the condition, fetches the target word, and pushes or pops the three saved registers on a stack that grows toward lower addresses. It then commits the new register values in one cycle.

All memory traffic uses a single request/ready handshake. A request stays up, with its address and data held still, until `mem_ready` is seen at a rising edge. `pc_in` is the address of the branch opcode itself. Jump and call forms carry their target in the word at `pc_in+1`. Returns and pointer calls are single-word instructions. The low sixteen pointer slots hold hardware interrupt vectors and slot 16 holds the trap vector. A pointer call with one of those slot numbers therefore enters the matching handler the way the hardware would.

Top module: `branch_seq`

## Requirements
- R1: Only two patterns are accepted. The first is the branch subclass (instr[11:6] = 111011) where bit 3 is set, or bit 3 is clear with bits 2:0 = 000. The second is the pointer call (instr[11:7] = 11111). Any other word with `start` raises neither `busy`, a memory request nor `pc_we`.
- R2: With bit 3 set, bits 2:0 select a test. Values 0, 1, 2 and 3 require Z, C, N and V to be 1. Values 4, 5, 6 and 7 require Z, C, N and V to be 0.
- R3: A taken jump (bit 5 = 0, bit 4 = 0) reads the word at PC+1 and commits it as the new PC.
- R4: A branch whose test fails makes no memory access and does not update SP, F or S. It commits PC+2 for jump and call forms and PC+1 for return forms.
- R5: A taken call (bit 5 = 1, bit 4 = 0) first reads its target from PC+1. It then writes PC+2 to SP-1, F to SP-2 and S to SP-3, all modulo 4096. It commits the target as PC and SP-3 as SP.
- R6: A taken return (bit 4 = 1) reads S from SP, F from SP+1 and PC from SP+2. It commits all three along with SP+3.
- R7: A pointer call writes PC+1, F and S to SP-1, SP-2 and SP-3. After those writes it reads the word at the zero-extended 7-bit pointer instr[6:0]. It commits that word as PC and SP-3 as SP.
- R8: Each access is held, with a stable address, write enable and write data, until a rising edge where `mem_ready` is high. That edge completes the access.
- R9: `busy` is high from the cycle after acceptance through the commit cycle, and low after it. `start` and all other inputs are ignored while `busy` is high.
- R10: The commit is a single-cycle `pc_we` pulse. `f_we` and `s_we` pulse with it only for taken returns. `sp_we` pulses with it only for taken calls, returns and pointer calls.
- R11: In the branch subclass, bit 4 set selects a return whatever bit 5 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction strobe, sampled when idle |
| instr | input | 12 | Instruction word |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| pc_in | input | 12 | Address of the opcode |
| f_in | input | 12 | Current F register |
| s_in | input | 12 | Current S register |
| sp_in | input | 12 | Current stack pointer |
| mem_ready | input | 1 | Memory completes the access at this edge |
| mem_rdata | input | 12 | Read data, valid with mem_ready |
| busy | output | 1 | Instruction in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 12 | Access address |
| mem_wdata | output | 12 | Write data |
| pc_we | output | 1 | Commit strobe for PC |
| pc_out | output | 12 | New PC |
| f_we | output | 1 | Commit strobe for F |
| f_out | output | 12 | New F |
| s_we | output | 1 | Commit strobe for S |
| s_out | output | 12 | New S |
| sp_we | output | 1 | Commit strobe for SP |
| sp_out | output | 12 | New SP |

## Verification
The assertions check the handshake on every cycle. They confirm that a stalled request holds its address and data, that nothing is requested while idle, and that the commit is a lone pulse after which `busy` drops. They also confirm that the F and S strobes arrive only together with SP and PC, and that back-to-back writes walk down one address while back-to-back reads walk up one. The bench scenarios are needed for the rest: which flag each condition code tests, the exact data pushed and where, the order in which values are restored, the fall-through addresses, and the pointer lookup. Those results depend on memory contents and flags that only a reference model in the bench can predict.

// File: rtl/branch_seq.sv
module branch_seq #(
  parameter int W    = 12,
  parameter int PTRW = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [11:0]  instr,
  input  logic         flag_z,
  input  logic         flag_c,
  input  logic         flag_n,
  input  logic         flag_v,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] f_in,
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] sp_in,
  input  logic         mem_ready,
  input  logic [W-1:0] mem_rdata,
  output logic         busy,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         pc_we,
  output logic [W-1:0] pc_out,
  output logic         f_we,
  output logic [W-1:0] f_out,
  output logic         s_we,
  output logic [W-1:0] s_out,
  output logic         sp_we,
  output logic [W-1:0] sp_out
);

  typedef enum logic [2:0] {IDLE, FETCH, PUSH, PTR, POP, DONE} st_t;
  typedef enum logic [1:0] {K_JMP, K_CALL, K_RET, K_ZC} kind_t;

  st_t            st;
  kind_t          kind;
  logic [1:0]     cnt;
  logic           stk;
  logic [PTRW-1:0] ptr_r;
  logic [W-1:0]   pc_r, f_r, s_r, sp_r, tgt, ret_pc, wd;

  logic is_br, is_zc, flag_sel, cond_true, accept, hit;
  kind_t kind_d;

  assign is_br = (instr[11:6] == 6'b111011) && (instr[3] || instr[2:0] == 3'b000);
  assign is_zc = (instr[11:7] == 5'b11111);

  always_comb
    case (instr[1:0])
      2'd0:    flag_sel = flag_z;
      2'd1:    flag_sel = flag_c;
      2'd2:    flag_sel = flag_n;
      default: flag_sel = flag_v;
    endcase

  assign cond_true = instr[3] ? (flag_sel ^ instr[2]) : 1'b1;
  assign accept    = start && (st == IDLE) && (is_br || is_zc);
  assign kind_d    = is_zc ? K_ZC : instr[4] ? K_RET : instr[5] ? K_CALL : K_JMP;
  assign hit       = mem_req && mem_ready;
  assign ret_pc    = pc_r + ((kind == K_ZC) ? W'(1) : W'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      kind  <= K_JMP;
      cnt   <= '0;
      stk   <= 1'b0;
      ptr_r <= '0;
      pc_r  <= '0;
      f_r   <= '0;
      s_r   <= '0;
      sp_r  <= '0;
      tgt   <= '0;
    end else begin
      case (st)
        IDLE: if (accept) begin
          pc_r  <= pc_in;
          f_r   <= f_in;
          s_r   <= s_in;
          sp_r  <= sp_in;
          ptr_r <= instr[PTRW-1:0];
          kind  <= kind_d;
          cnt   <= '0;
          if (is_zc) begin
            st  <= PUSH;
            stk <= 1'b1;
          end else if (!cond_true) begin
            st  <= DONE;
            stk <= 1'b0;
            tgt <= pc_in + (instr[4] ? W'(1) : W'(2));
          end else if (instr[4]) begin
            st  <= POP;
            stk <= 1'b1;
          end else begin
            st  <= FETCH;
            stk <= instr[5];
          end
        end
        FETCH: if (hit) begin
          tgt <= mem_rdata;
          st  <= (kind == K_CALL) ? PUSH : DONE;
        end
        PUSH: if (hit) begin
          sp_r <= sp_r - W'(1);
          cnt  <= cnt + 2'd1;
          if (cnt == 2'd2) st <= (kind == K_ZC) ? PTR : DONE;
        end
        PTR: if (hit) begin
          tgt <= mem_rdata;
          st  <= DONE;
        end
        POP: if (hit) begin
          sp_r <= sp_r + W'(1);
          cnt  <= cnt + 2'd1;
          case (cnt)
            2'd0:    s_r <= mem_rdata;
            2'd1:    f_r <= mem_rdata;
            default: begin
              tgt <= mem_rdata;
              st  <= DONE;
            end
          endcase
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_comb
    case (cnt)
      2'd0:    wd = ret_pc;
      2'd1:    wd = f_r;
      default: wd = s_r;
    endcase

  always_comb
    case (st)
      FETCH:   mem_addr = pc_r + W'(1);
      PUSH:    mem_addr = sp_r - W'(1);
      PTR:     mem_addr = {{(W-PTRW){1'b0}}, ptr_r};
      POP:     mem_addr = sp_r;
      default: mem_addr = '0;
    endcase

  assign busy      = (st != IDLE);
  assign mem_req   = (st == FETCH) || (st == PUSH) || (st == PTR) || (st == POP);
  assign mem_we    = (st == PUSH);
  assign mem_wdata = (st == PUSH) ? wd : '0;
  assign pc_we     = (st == DONE);
  assign pc_out    = tgt;
  assign f_we      = (st == DONE) && stk && (kind == K_RET);
  assign s_we      = f_we;
  assign f_out     = f_r;
  assign s_out     = s_r;
  assign sp_we     = (st == DONE) && stk;
  assign sp_out    = sp_r;

endmodule

// File: rtl/branch_seq_chk.sv
module branch_seq_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         mem_req,
  input logic         mem_we,
  input logic         mem_ready,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         pc_we,
  input logic         f_we,
  input logic         s_we,
  input logic         sp_we
);

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !pc_we));

  assert_commit_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> !busy);

  assert_commit_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> !pc_we);

  assert_fs_with_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (f_we || s_we) |-> (f_we && s_we && sp_we && pc_we));

  assert_sp_with_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> pc_we);

  assert_push_walks_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready) |=> (!(mem_req && mem_we) || mem_addr == $past(mem_addr) - W'(1)));

  assert_pop_walks_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready) |=> (!(mem_req && !mem_we) || mem_addr == $past(mem_addr) + W'(1)));

endmodule

bind branch_seq branch_seq_chk #(.W(W)) u_chk (.*);

// File: tb/branch_seq_test.sv
`timescale 1ns/1ps
module branch_seq_test;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n, start, flag_z, flag_c, flag_n, flag_v, mem_ready;
  logic [11:0] instr, pc_in, f_in, s_in, sp_in, mem_rdata;
  logic busy, mem_req, mem_we, pc_we, f_we, s_we, sp_we;
  logic [11:0] mem_addr, mem_wdata, pc_out, f_out, s_out, sp_out;

  branch_seq uut (.*);

  logic [11:0] mem [0:4095];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_req && mem_ready && mem_we) mem[mem_addr] <= mem_wdata;

  logic [11:0] la [0:255];
  logic        lw [0:255];
  logic [11:0] ld [0:255];
  int nlog = 0, n_pcwe = 0, n_busy = 0, cyc = 0;
  int nchk = 0, nerr = 0;
  bit rdy_all = 0;

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      la[nlog % 256] <= mem_addr;
      lw[nlog % 256] <= mem_we;
      ld[nlog % 256] <= mem_we ? mem_wdata : mem_rdata;
      nlog <= nlog + 1;
    end
    if (pc_we) n_pcwe <= n_pcwe + 1;
    if (busy)  n_busy <= n_busy + 1;
  end

  always @(negedge clk) mem_ready <= rdy_all ? 1'b1 : ($urandom % 3 != 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit cond_ok(input logic [11:0] ins, input logic [3:0] fl);
    logic f;
    if (!ins[3]) return 1'b1;
    f = fl[3 - ins[1:0]];
    return ins[2] ? !f : f;
  endfunction

  task automatic run(input logic [11:0] ins, input logic [3:0] fl, input logic [11:0] pc, f, s, sp,
                     input bit hold, input string tag);
    logic [11:0] ea [8];
    logic        ew [8];
    logic [11:0] ed [8];
    int en = 0, base, pb, bb, k;
    bit zc, br, ret, call, tk, spwe = 0, fwe = 0;
    logic [11:0] epc, ef = f, es = s, esp = sp, p;
    string t;
    zc = ins[11:7] == 5'b11111;
    br = ins[11:6] == 6'b111011 && (ins[3] || ins[2:0] == 3'b000);
    @(negedge clk);
    instr = ins; {flag_z, flag_c, flag_n, flag_v} = fl;
    pc_in = pc; f_in = f; s_in = s; sp_in = sp; start = 1;
    base = nlog; pb = n_pcwe; bb = n_busy;
    if (!(zc || br)) begin
      @(negedge clk); start = 0;
      repeat (6) @(negedge clk);
      chk("R1", "busy cycles", n_busy - bb, 0);
      chk("R1", "commits", n_pcwe - pb, 0);
      chk("R1", "accesses", nlog - base, 0);
      return;
    end
    ret  = !zc && ins[4];
    call = !zc && !ret && ins[5];
    tk   = zc || cond_ok(ins, fl);
    if (!tk) begin
      epc = pc + (ret ? 12'd1 : 12'd2);
      t = "R4";
    end else if (zc) begin
      p = {5'b0, ins[6:0]};
      ea[0] = sp - 1; ew[0] = 1; ed[0] = pc + 1;
      ea[1] = sp - 2; ew[1] = 1; ed[1] = f;
      ea[2] = sp - 3; ew[2] = 1; ed[2] = s;
      epc = mem[p];
      for (int i = 0; i < 3; i++) if (ea[i] == p) epc = ed[i];
      ea[3] = p; ew[3] = 0; ed[3] = epc; en = 4;
      esp = sp - 3; spwe = 1; t = "R7";
    end else if (ret) begin
      es = mem[sp]; ef = mem[12'(sp + 1)]; epc = mem[12'(sp + 2)];
      ea[0] = sp; ew[0] = 0; ed[0] = es;
      ea[1] = sp + 1; ew[1] = 0; ed[1] = ef;
      ea[2] = sp + 2; ew[2] = 0; ed[2] = epc; en = 3;
      esp = sp + 3; spwe = 1; fwe = 1; t = "R6";
    end else begin
      epc = mem[12'(pc + 1)];
      ea[0] = pc + 1; ew[0] = 0; ed[0] = epc; en = 1;
      if (call) begin
        ea[1] = sp - 1; ew[1] = 1; ed[1] = pc + 2;
        ea[2] = sp - 2; ew[2] = 1; ed[2] = f;
        ea[3] = sp - 3; ew[3] = 1; ed[3] = s; en = 4;
        esp = sp - 3; spwe = 1; t = "R5";
      end else t = "R3";
    end
    if (tag != "") t = tag;
    @(negedge clk);
    if (hold) begin
      start = 1; instr = 12'o7320; pc_in = ~pc; sp_in = ~sp; f_in = ~f; s_in = ~s;
    end else start = 0;
    chk("R9", "busy after accept", busy, 1);
    k = 0;
    while (!pc_we && k < 300) begin @(negedge clk); k++; end
    if (k >= 300) chk(t, "commit timeout", 0, 1);
    chk(t, "pc_out", pc_out, epc);
    chk("R10", "sp_we", sp_we, spwe);
    chk("R10", "f_we", f_we, fwe);
    chk("R10", "s_we", s_we, fwe);
    if (spwe) chk(t, "sp_out", sp_out, esp);
    if (fwe) begin
      chk(t, "f_out", f_out, ef);
      chk(t, "s_out", s_out, es);
    end
    chk(t, "access count", nlog - base, en);
    for (int i = 0; i < en && i < nlog - base; i++) begin
      chk(t, $sformatf("access %0d addr", i), la[(base + i) % 256], ea[i]);
      chk(t, $sformatf("access %0d write", i), lw[(base + i) % 256], ew[i]);
      chk(t, $sformatf("access %0d data", i), ld[(base + i) % 256], ed[i]);
    end
    start = 0;
    @(negedge clk);
    chk("R9", "busy after commit", busy, 0);
    chk("R10", "pc_we after commit", pc_we, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4096; i++) mem[i] = 12'(i * 29 + 7);
    rst_n = 0; start = 0; instr = 0; {flag_z, flag_c, flag_n, flag_v} = 0;
    pc_in = 0; f_in = 0; s_in = 0; sp_in = 0;
    repeat (3) @(negedge clk);
    chk("R9", "reset busy", busy, 0);
    chk("R8", "reset mem_req", mem_req, 0);
    chk("R10", "reset pc_we", pc_we, 0);
    chk("R10", "reset sp_we", sp_we, 0);
    rst_n = 1;

    rdy_all = 1;
    run(12'o7300, 4'b0000, 12'h100, 12'h0A5, 12'h05A, 12'h900, 0, "R3");
    run(12'o7340, 4'b0000, 12'h200, 12'h123, 12'h456, 12'h900, 0, "R5");
    run(12'o7320, 4'b0000, 12'h300, 12'h0, 12'h0, 12'h8FD, 0, "R6");
    rdy_all = 0;
    for (int cc = 0; cc < 8; cc++)
      for (int v = 0; v < 2; v++) begin
        logic [3:0] fl;
        fl = v ? 4'b1111 : 4'b0000;
        run(12'(12'o7310 | cc), fl, 12'h180 + 12'(cc * 4), 12'h11, 12'h22, 12'hA00, 0, "R2");
        run(12'(12'o7310 | cc), ~(4'b1000 >> cc[1:0]) ^ (v ? 4'hF : 4'h0), 12'h1C0, 12'h11, 12'h22, 12'hA00, 0, "R2");
      end
    run(12'o7350, 4'b0000, 12'h400, 12'h1, 12'h2, 12'hB00, 0, "R4");
    run(12'o7334, 4'b1000, 12'h410, 12'h1, 12'h2, 12'hB00, 0, "R4");
    run(12'o7334, 4'b0000, 12'h420, 12'h1, 12'h2, 12'hB00, 0, "R6");
    run(12'o7621, 4'b0000, 12'h500, 12'h333, 12'h444, 12'hC00, 0, "R7");
    run(12'o7620, 4'b0000, 12'h510, 12'h333, 12'h444, 12'hC00, 0, "R7");
    run(12'o7777, 4'b0000, 12'h520, 12'h333, 12'h444, 12'hC00, 0, "R7");
    run(12'o7360, 4'b0000, 12'h530, 12'h0, 12'h0, 12'hC40, 0, "R11");
    run(12'o7305, 4'b0000, 12'h540, 12'h0, 12'h0, 12'hC40, 0, "R1");
    run(12'o7200, 4'b0000, 12'h540, 12'h0, 12'h0, 12'hC40, 0, "R1");
    run(12'o7340, 4'b0000, 12'h550, 12'h777, 12'h666, 12'hD00, 1, "R9");
    run(12'o7340, 4'b0000, 12'h560, 12'h701, 12'h702, 12'h001, 0, "R5");

    for (int it = 0; it < 300; it++) begin
      logic [11:0] ins;
      int cat;
      cat = $urandom % 8;
      if (cat < 5) ins = {6'b111011, 6'($urandom)};
      else if (cat < 7) ins = {5'b11111, 7'($urandom)};
      else ins = {3'b111, 3'($urandom % 3), 6'($urandom)};
      run(ins, 4'($urandom), 12'h100 + 12'($urandom % 12'h600), 12'($urandom), 12'($urandom),
          12'h800 + 12'($urandom % 12'h7FE), ($urandom % 4) == 0, (it % 2) ? "R8" : "");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule